// File: doc/BRIEF.md
# Shifted-Operand Accumulator Subtract Unit

This block keeps a 32-bit accumulator and on each operation subtracts a 16-bit operand from it. The operand is first widened, by sign or zero extension as a mode bit selects, and then moved left by a shift count. The count comes from the four low bits of a separate shift register input. Each operation updates zero, negative, carry and overflow flags. It also updates a small signed counter that records signed overflows, unless saturation mode is on. In saturation mode an overflowing result is clamped to the largest positive or most negative value.

A start strobe launches the operation. A repeat count N makes the block run it N+1 times, one iteration per clock. The operand, shift register and mode inputs are read live on every iteration, so the caller may present a new fetched operand each cycle. `busy` stays high while more iterations remain. `done` pulses in the cycle that shows the final result. The surrounding pipeline fetches the operand, decodes the instruction and handles addressing. This block does none of those.

Top module: `shsub_unit`

## Requirements
- R1: The shift count is `shiftRegIn[3:0]`, giving 0 to 15. Bits 15:4 of `shiftRegIn` have no effect on any result.
- R2: The operand is widened to 32 bits by copying bit 15 when `signExtMode`=1 and by filling with zeros when `signExtMode`=0. It is then shifted left, and the vacated low bits are zero.
- R3: With no overflow, or with `satMode`=0, the new `accOut` is the old `accOut` minus the widened, shifted operand, taken modulo 2^32.
- R4: After each iteration `zFlag`=1 exactly when `accOut` is zero, and `nFlag` equals `accOut[31]`.
- R5: `cFlag`=0 when the unsigned subtraction borrows, meaning the old accumulator is below the shifted operand as unsigned numbers. Otherwise `cFlag`=1.
- R6: `vFlag` is set by any signed overflow. It keeps its value when an iteration does not overflow, and only reset clears it.
- R7: With `satMode`=0, `ovCount` (6-bit two's complement, wrapping) goes up by 1 on a positive overflow and down by 1 on a negative overflow. A positive overflow is a true signed difference above 0x7FFFFFFF. A negative overflow is one below -0x80000000.
- R8: With `satMode`=1, an overflowing iteration loads 0x7FFFFFFF (positive overflow) or 0x80000000 (negative overflow), and `ovCount` does not change.
- R9: A start taken while idle runs `repeatCount`+1 iterations, one per clock. The first iteration lands on the start edge. `busy` is high while iterations remain. `done` is high for one cycle, the cycle in which the final result and flags appear, and is followed by `busy` low.
- R10: A start strobe raised while `busy`=1 is ignored: it neither adds iterations nor restarts the sequence.
- R11: A synchronous `rst` clears `accOut`, all four flags, `ovCount`, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Launch strobe, taken only while idle |
| operandIn | input | 16 | Fetched operand, read on every iteration |
| shiftRegIn | input | 16 | Shift register; the low 4 bits give the count |
| signExtMode | input | 1 | 1 = sign extend, 0 = zero extend |
| satMode | input | 1 | 1 = saturate on overflow and freeze the counter |
| repeatCount | input | 8 | Extra iteration count N (N+1 iterations in total) |
| accOut | output | 32 | Accumulator |
| zFlag | output | 1 | Zero flag |
| nFlag | output | 1 | Negative flag |
| cFlag | output | 1 | Carry flag, 0 on borrow |
| vFlag | output | 1 | Sticky overflow flag |
| ovCount | output | 6 | Signed overflow counter |
| busy | output | 1 | More iterations remain |
| done | output | 1 | Final result visible this cycle |

## Verification
Any fault in the accumulator shows up in `accOut` and in the zero and negative flags in the cycle after the iteration that caused it. Every later iteration carries the error forward, so a fault in one repeated step still shows at the final `done`. An overflow misclassified as positive or negative moves `ovCount` in the wrong direction, or in saturation mode clamps to the wrong rail. The sticky `vFlag` keeps such an event visible until reset. A fault in the repeat counter shows as `done` arriving early or late, or as extra iterations after a start strobe arrives while busy. Extra iterations change `accOut` a cycle after the sequence should have ended.

// File: rtl/shsub_pkg.sv
package shsub_pkg;

  // Strobes from the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic opFire;    // perform one subtraction at this edge
    logic lastIter;  // this edge performs the final iteration
  } ctrlStrobes_t;

endpackage

// File: rtl/shsub_ctrl.sv
module shsub_ctrl
  import shsub_pkg::*;
#(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startIn,
  input  logic [REP_W-1:0] repeatCount,
  output ctrlStrobes_t     strobes,
  output logic             busy,
  output logic             done
);

  logic [REP_W-1:0] remainingQ;
  logic             acceptStart;

  assign busy        = (remainingQ != '0);
  assign acceptStart = startIn && !busy;

  always_comb begin
    strobes.opFire   = acceptStart || busy;
    strobes.lastIter = acceptStart ? (repeatCount == '0)
                                   : (busy && (remainingQ == REP_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remainingQ <= '0;
      done       <= 1'b0;
    end else begin
      if (acceptStart)
        remainingQ <= repeatCount;
      else if (busy)
        remainingQ <= remainingQ - REP_W'(1);
      done <= strobes.opFire && strobes.lastIter;
    end
  end

  // R9: when the sequence ends, the final result is being flagged.
  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9: done never overlaps remaining iterations.
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: a strobe while busy only lets the countdown continue.
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && startIn) |=> (remainingQ == $past(remainingQ) - REP_W'(1)));

endmodule

// File: rtl/shsub_datapath.sv
module shsub_datapath
  import shsub_pkg::*;
#(
  parameter int ACC_W      = 32,
  parameter int OPND_W     = 16,
  parameter int REG_W      = 16,
  parameter int SHIFT_BITS = 4,
  parameter int OVC_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [OPND_W-1:0] operandIn,
  input  logic [REG_W-1:0]  shiftRegIn,
  input  logic              signExtMode,
  input  logic              satMode,
  output logic [ACC_W-1:0]  accOut,
  output logic              zFlag,
  output logic              nFlag,
  output logic              cFlag,
  output logic              vFlag,
  output logic [OVC_W-1:0]  ovCount
);

  localparam logic [ACC_W-1:0] SAT_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_NEG = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [OVC_W-1:0] OVC_ONE = {{(OVC_W-1){1'b0}}, 1'b1};

  logic [SHIFT_BITS-1:0] shiftAmt;
  logic [ACC_W-1:0]      extended;
  logic [ACC_W-1:0]      shifted;
  logic [ACC_W:0]        diffWide;
  logic [ACC_W-1:0]      rawDiff;
  logic [ACC_W-1:0]      resultNext;
  logic                  posOv;
  logic                  negOv;
  logic                  unusedShiftHigh;

  assign shiftAmt        = shiftRegIn[SHIFT_BITS-1:0];
  assign unusedShiftHigh = ^shiftRegIn[REG_W-1:SHIFT_BITS];

  // Widening: low part is the operand, each upper bit is the fill bit.
  assign extended[OPND_W-1:0] = operandIn;
  for (genvar gi = OPND_W; gi < ACC_W; gi++) begin : gFill
    assign extended[gi] = signExtMode & operandIn[OPND_W-1];
  end

  assign shifted  = extended << shiftAmt;
  assign diffWide = {1'b0, accOut} - {1'b0, shifted};
  assign rawDiff  = diffWide[ACC_W-1:0];

  // Signed overflow: operands of opposite sign and result sign flipped.
  assign posOv = !accOut[ACC_W-1] &&  shifted[ACC_W-1] &&  rawDiff[ACC_W-1];
  assign negOv =  accOut[ACC_W-1] && !shifted[ACC_W-1] && !rawDiff[ACC_W-1];

  always_comb begin
    resultNext = rawDiff;
    if (satMode && posOv) resultNext = SAT_POS;
    if (satMode && negOv) resultNext = SAT_NEG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accOut  <= '0;
      zFlag   <= 1'b0;
      nFlag   <= 1'b0;
      cFlag   <= 1'b0;
      vFlag   <= 1'b0;
      ovCount <= '0;
    end else if (strobes.opFire) begin
      accOut <= resultNext;
      zFlag  <= (resultNext == '0);
      nFlag  <= resultNext[ACC_W-1];
      cFlag  <= !diffWide[ACC_W];
      if (posOv || negOv) vFlag <= 1'b1;
      if (!satMode) begin
        if (posOv)      ovCount <= ovCount + OVC_ONE;
        else if (negOv) ovCount <= ovCount - OVC_ONE;
      end
    end
  end

  // R4: flags agree with the registered accumulator after an iteration.
  assert_flags_track_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.opFire |=> ((zFlag == (accOut == '0)) && (nFlag == accOut[ACC_W-1])));

  // R6: the overflow flag never falls outside reset.
  assert_v_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    vFlag |=> vFlag);

  // R8: saturation mode freezes the counter.
  assert_sat_count_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.opFire && satMode) |=> $stable(ovCount));

  // R9: without an iteration the arithmetic state holds.
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.opFire |=> ($stable(accOut) && $stable(ovCount) && $stable(cFlag)));

endmodule

// File: rtl/shsub_unit.sv
module shsub_unit
  import shsub_pkg::*;
#(
  parameter int ACC_W      = 32,
  parameter int OPND_W     = 16,
  parameter int REG_W      = 16,
  parameter int SHIFT_BITS = 4,
  parameter int OVC_W      = 6,
  parameter int REP_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic [OPND_W-1:0] operandIn,
  input  logic [REG_W-1:0]  shiftRegIn,
  input  logic              signExtMode,
  input  logic              satMode,
  input  logic [REP_W-1:0]  repeatCount,
  output logic [ACC_W-1:0]  accOut,
  output logic              zFlag,
  output logic              nFlag,
  output logic              cFlag,
  output logic              vFlag,
  output logic [OVC_W-1:0]  ovCount,
  output logic              busy,
  output logic              done
);

  ctrlStrobes_t strobes;

  shsub_ctrl #(.REP_W(REP_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .startIn     (startIn),
    .repeatCount (repeatCount),
    .strobes     (strobes),
    .busy        (busy),
    .done        (done)
  );

  shsub_datapath #(
    .ACC_W      (ACC_W),
    .OPND_W     (OPND_W),
    .REG_W      (REG_W),
    .SHIFT_BITS (SHIFT_BITS),
    .OVC_W      (OVC_W)
  ) u_datapath (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .operandIn   (operandIn),
    .shiftRegIn  (shiftRegIn),
    .signExtMode (signExtMode),
    .satMode     (satMode),
    .accOut      (accOut),
    .zFlag       (zFlag),
    .nFlag       (nFlag),
    .cFlag       (cFlag),
    .vFlag       (vFlag),
    .ovCount     (ovCount)
  );

endmodule

// File: tb/shsub_unit_bench.sv
module shsub_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startIn = 1'b0;
  logic [15:0] operandIn = '0;
  logic [15:0] shiftRegIn = '0;
  logic        signExtMode = 1'b0;
  logic        satMode = 1'b0;
  logic [7:0]  repeatCount = '0;
  logic [31:0] accOut;
  logic        zFlag, nFlag, cFlag, vFlag;
  logic [5:0]  ovCount;
  logic        busy, done;

  always #5 clk = ~clk;

  shsub_unit u_shsub_unit (
    .clk(clk), .rst(rst), .startIn(startIn), .operandIn(operandIn),
    .shiftRegIn(shiftRegIn), .signExtMode(signExtMode), .satMode(satMode),
    .repeatCount(repeatCount), .accOut(accOut), .zFlag(zFlag), .nFlag(nFlag),
    .cFlag(cFlag), .vFlag(vFlag), .ovCount(ovCount), .busy(busy), .done(done)
  );

  typedef struct {
    logic [31:0] acc;
    logic [3:0]  flags;   // {z, n, c, v}
    logic [5:0]  ovc;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mAcc;
  logic        mV;
  logic [5:0]  mOvc;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference step built from the requirements with wide signed arithmetic.
  task automatic modelStep(input logic [15:0] op, input logic [15:0] tr,
                           input logic sx, input logic sat, output expItem_t e);
    logic [31:0] ext;
    logic [31:0] sh;
    longint      d;
    logic        posOv, negOv, c;
    logic [31:0] res;
    ext   = sx ? {{16{op[15]}}, op} : {16'h0000, op};   // R2
    sh    = ext << tr[3:0];                               // R1
    d     = longint'($signed(mAcc)) - longint'($signed(sh));
    posOv = (d > 64'sd2147483647);
    negOv = (d < -64'sd2147483648);
    c     = (mAcc >= sh);                                 // R5
    res   = d[31:0];                                      // R3
    if (sat && posOv) res = 32'h7FFF_FFFF;                // R8
    if (sat && negOv) res = 32'h8000_0000;
    if (posOv || negOv) mV = 1'b1;                        // R6
    if (!sat) begin                                       // R7
      if (posOv) mOvc = mOvc + 6'd1;
      else if (negOv) mOvc = mOvc - 6'd1;
    end
    mAcc    = res;
    e.acc   = res;
    e.flags = {(res == 32'h0), res[31], c, mV};           // R4
    e.ovc   = mOvc;
  endtask

  task automatic issueOp(input logic [15:0] op, input logic [15:0] tr,
                         input logic sx, input logic sat, input int n,
                         input string tag);
    expItem_t e;
    for (int i = 0; i <= n; i++) modelStep(op, tr, sx, sat, e);
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    operandIn = op; shiftRegIn = tr; signExtMode = sx; satMode = sat;
    repeatCount = 8'(n); startIn = 1'b1;
    @(posedge clk);
    #1 startIn = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) chk({"R9 busy during repeat ", tag}, {31'b0, busy}, 32'd1);
      @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    #1 rst = 1'b0;
    mAcc = '0; mV = 1'b0; mOvc = '0;
    expQ.delete();
    @(negedge clk);
    chk("R11 reset acc", accOut, 32'h0);
    chk("R11 reset flags", {28'b0, zFlag, nFlag, cFlag, vFlag}, 32'h0);
    chk("R11 reset ovCount busy done", {24'b0, ovCount, busy, done}, 32'h0);
  endtask

  // Monitor: compare every completed sequence against the scoreboard.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expQ.size() == 0) begin
        chk("R9 unexpected done", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk({"R3 acc ", e.tag}, accOut, e.acc);
        chk({"R4/R5/R6 flags ", e.tag}, {28'b0, zFlag, nFlag, cFlag, vFlag}, {28'b0, e.flags});
        chk({"R7/R8 ovCount ", e.tag}, {26'b0, ovCount}, {26'b0, e.ovc});
      end
    end
  end

  initial begin
    doReset();
    issueOp(16'hFFFF, 16'h0004, 1'b1, 1'b0, 0, "R2 sign extension");
    issueOp(16'h0002, 16'hFFF3, 1'b0, 1'b0, 0, "R1 high shift bits ignored, R4 zero");
    issueOp(16'hFFFF, 16'h0000, 1'b0, 1'b0, 0, "R2 zero extension, R5 borrow");
    issueOp(16'h0003, 16'h0001, 1'b1, 1'b0, 0, "R3 plain subtract");
    issueOp(16'h8000, 16'h000F, 1'b1, 1'b0, 3, "R7 positive overflow in repeat");
    issueOp(16'h8000, 16'h000F, 1'b1, 1'b1, 3, "R8 saturate positive");
    issueOp(16'h7FFF, 16'h000F, 1'b0, 1'b0, 4, "R7 negative overflow");
    issueOp(16'h7FFF, 16'h000F, 1'b0, 1'b1, 4, "R8 saturate negative");

    // R10: start held high through a busy sequence adds no iterations.
    begin
      expItem_t e;
      for (int i = 0; i <= 3; i++) modelStep(16'h0001, 16'h0000, 1'b1, 1'b0, e);
      e.tag = "R10 start while busy";
      expQ.push_back(e);
      @(negedge clk);
      operandIn = 16'h0001; shiftRegIn = 16'h0000; signExtMode = 1'b1;
      satMode = 1'b0; repeatCount = 8'd3; startIn = 1'b1;
      for (int i = 0; i < 4; i++) @(posedge clk);
      #1 startIn = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R10 idle after sequence", {31'b0, busy}, 32'd0);
      @(negedge clk);
      chk("R10 no extra iteration", accOut, e.acc);
    end

    doReset();
    @(negedge clk);
    chk("R11 scoreboard drained", 32'(expQ.size()), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule